// File: doc/BRIEF.md
# Dual-Length Serial Configuration Loader

This block receives per-channel brightness settings over a three-wire serial link (shift clock, data, latch) and holds them in two parallel registers. A mode input picks the target. With mode low the shift chain is 192 bits long and loads a grayscale register of sixteen 12-bit fields. With mode high the chain is 96 bits long and loads a correction register of sixteen 6-bit fields. The serial output always presents the top bit of the active chain, so several loaders can be daisy-chained and a host can read data back.

Each grayscale latch ends by replacing the chain with a 192-bit status word. The word holds the per-channel open-load flags, the over-temperature flag and a copy of the correction register, and it can be clocked out while the next grayscale packet is clocked in. The first grayscale load after a correction load completes only on one extra shift clock after the latch pulse. The shift clock and the latch are sampled as strobes in the system clock domain, and their edges are detected there. PWM generation and current scaling belong to other blocks.

Top module: `dual_chain_loader`

## Requirements
- R1: After reset the grayscale register, the correction register, the whole shift chain and `sdataOut` are all zero.
- R2: With `modeIn` low, each rising edge of `sclkIn` shifts `sdataIn` into a 192-bit chain, MSB first. The first 12 bits shifted in belong to channel 15 and the last 12 to channel 0. Channel n therefore lands in `gsReg[12n+11:12n]`.
- R3: With `modeIn` high, the chain is 96 bits long, with 6 bits per channel and channel 15 first. Channel n lands in `dcReg[6n+5:6n]`. A bit entering `sdataIn` reaches `sdataOut` after 96 shift edges.
- R4: While `latchIn` is high, the register chosen by `modeIn` follows the chain contents. While `latchIn` is low, both registers hold whatever further shifting occurs.
- R5: When `latchIn` falls in grayscale mode, the chain is loaded with a status word. Bit n (0..15) is the open-load flag of channel n, bit 16 is the thermal flag, bits 24..119 are the correction register, and all other bits are zero. The flags are taken at that falling edge.
- R6: `sdataOut` is chain bit 191 in grayscale mode and chain bit 95 in correction mode. The status MSB shows as soon as the status word is loaded, and each later shift edge presents the next lower bit.
- R7: After a correction latch, the next grayscale latch pulse leaves `gsReg` unchanged. The first shift edge after that pulse copies the chain into `gsReg` and loads the status word, and it shifts nothing in. Later grayscale latches act at once again.
- R8: `modeIn` changes only while `latchIn` is low, and such a change alters neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclkIn | input | 1 | Serial shift strobe, rising edge active |
| sdataIn | input | 1 | Serial data, MSB first |
| latchIn | input | 1 | Level latch strobe |
| modeIn | input | 1 | 0 = grayscale target, 1 = correction target |
| openFlags | input | 16 | Per-channel open-load flags |
| thermalFlag | input | 1 | Over-temperature flag |
| sdataOut | output | 1 | Top bit of the active chain |
| gsReg | output | 192 | Grayscale register, channel 15 in the top bits |
| dcReg | output | 96 | Correction register, channel 15 in the top bits |

## Verification
A chain that is misaligned by one position shows up right away as a shifted field in `gsReg` or `dcReg` after the next latch, and as a wrong bit on `sdataOut` at the first readback edge. A wrong status layout, or a deferred-load flag left in the wrong state, stays hidden until the status word is clocked out. A full 192-edge readback is therefore compared bit by bit, both after a normal grayscale latch and after the deferred one. The deferred-load corner is covered in both directions: `gsReg` must stay unchanged through the latch pulse and must change on the very next shift edge.

// File: rtl/loader_pkg.sv
package loader_pkg;
  typedef struct packed {
    logic shiftEn;
    logic gsCopy;
    logic dcCopy;
    logic statusLoad;
    logic longChain;
  } ctlStrobes_t;

  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_AFTER_DC = 2'd1,
    SEQ_ARMED    = 2'd2
  } seqState_t;
endpackage

// File: rtl/loader_ctrl.sv
module loader_ctrl
  import loader_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclkIn,
  input  logic        latchIn,
  input  logic        modeIn,
  output ctlStrobes_t strobes
);
  logic      sclkQ, latchQ;
  seqState_t state, stateNext;
  logic      sclkRise, latchFall, gsPath, normalGs, deferFire;

  assign sclkRise  = sclkIn & ~sclkQ;
  assign latchFall = ~latchIn & latchQ;
  assign gsPath    = ~modeIn;
  assign normalGs  = (state == SEQ_IDLE);
  // Deferred grayscale update completes on the first shift edge after arming
  assign deferFire = (state == SEQ_ARMED) & sclkRise & gsPath;

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_IDLE:     if (latchFall && modeIn) stateNext = SEQ_AFTER_DC;
      SEQ_AFTER_DC: if (latchFall && gsPath) stateNext = SEQ_ARMED;
      SEQ_ARMED: begin
        if (deferFire)                stateNext = SEQ_IDLE;
        else if (latchFall && modeIn) stateNext = SEQ_AFTER_DC;
      end
      default:                        stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      latchQ <= 1'b0;
      state  <= SEQ_IDLE;
    end else begin
      sclkQ  <= sclkIn;
      latchQ <= latchIn;
      state  <= stateNext;
    end
  end

  always_comb begin
    strobes.shiftEn    = sclkRise & ~deferFire;
    strobes.gsCopy     = (latchIn & gsPath & normalGs) | deferFire;
    strobes.dcCopy     = latchIn & modeIn;
    strobes.statusLoad = (latchFall & gsPath & normalGs) | deferFire;
    strobes.longChain  = gsPath;
  end
endmodule

// File: rtl/loader_datapath.sv
module loader_datapath
  import loader_pkg::*;
#(
  parameter int CH   = 16,
  parameter int GS_W = 12,
  parameter int DC_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdataIn,
  input  ctlStrobes_t        strobes,
  input  logic [CH-1:0]      openFlags,
  input  logic               thermalFlag,
  output logic               sdataOut,
  output logic [CH*GS_W-1:0] gsReg,
  output logic [CH*DC_W-1:0] dcReg
);
  localparam int GS_LEN = CH * GS_W;
  localparam int DC_LEN = CH * DC_W;
  localparam int DC_POS = ((CH + 1 + 7) / 8) * 8;

  logic [GS_LEN-1:0] chain;
  logic [GS_LEN-1:0] statusWord;

  always_comb begin
    statusWord                  = '0;
    statusWord[CH-1:0]          = openFlags;
    statusWord[CH]              = thermalFlag;
    statusWord[DC_POS +: DC_LEN] = dcReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chain <= '0;
      gsReg <= '0;
      dcReg <= '0;
    end else begin
      if (strobes.statusLoad)   chain <= statusWord;
      else if (strobes.shiftEn) chain <= {chain[GS_LEN-2:0], sdataIn};
      if (strobes.gsCopy) gsReg <= chain;
      if (strobes.dcCopy) dcReg <= chain[DC_LEN-1:0];
    end
  end

  assign sdataOut = strobes.longChain ? chain[GS_LEN-1] : chain[DC_LEN-1];
endmodule

// File: rtl/dual_chain_loader.sv
module dual_chain_loader
  import loader_pkg::*;
#(
  parameter int CH   = 16,
  parameter int GS_W = 12,
  parameter int DC_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclkIn,
  input  logic               sdataIn,
  input  logic               latchIn,
  input  logic               modeIn,
  input  logic [CH-1:0]      openFlags,
  input  logic               thermalFlag,
  output logic               sdataOut,
  output logic [CH*GS_W-1:0] gsReg,
  output logic [CH*DC_W-1:0] dcReg
);
  ctlStrobes_t strobes;

  loader_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .latchIn(latchIn),
    .modeIn(modeIn), .strobes(strobes)
  );

  loader_datapath #(.CH(CH), .GS_W(GS_W), .DC_W(DC_W)) u_dp (
    .clk(clk), .rstN(rstN), .sdataIn(sdataIn), .strobes(strobes),
    .openFlags(openFlags), .thermalFlag(thermalFlag),
    .sdataOut(sdataOut), .gsReg(gsReg), .dcReg(dcReg)
  );
endmodule

// File: rtl/dual_chain_loader_chk.sv
module dual_chain_loader_chk #(
  parameter int CH   = 16,
  parameter int GS_W = 12,
  parameter int DC_W = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               sclkIn,
  input logic               latchIn,
  input logic               modeIn,
  input logic               sdataOut,
  input logic [CH*GS_W-1:0] gsReg,
  input logic [CH*DC_W-1:0] dcReg
);
  // R8: mode may only move while latch is low
  a_r8_mode_latch_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeIn) |-> !latchIn);

  // R4: correction register holds while latch is low
  a_r4_dc_hold: assert property (@(posedge clk) disable iff (!rstN)
    !latchIn |=> $stable(dcReg));

  // R4, R7: grayscale register moves only on latch or a deferred shift edge
  a_r4_gs_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!latchIn && !sclkIn) |=> $stable(gsReg));

  // R6: serial output moves only on shift, latch release or mode change
  a_r6_sout_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!sclkIn && !latchIn && !$past(latchIn)) |=> ($stable(sdataOut) || !$stable(modeIn)));
endmodule

bind dual_chain_loader dual_chain_loader_chk #(.CH(CH), .GS_W(GS_W), .DC_W(DC_W)) u_chk (.*);

// File: tb/dual_chain_loader_bench.sv
module dual_chain_loader_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         sclkIn = 1'b0, sdataIn = 1'b0, latchIn = 1'b0, modeIn = 1'b0;
  logic [15:0]  openFlags = 16'h0;
  logic         thermalFlag = 1'b0;
  logic         sdataOut;
  logic [191:0] gsReg;
  logic [95:0]  dcReg;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dual_chain_loader u_dual_chain_loader (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .sdataIn(sdataIn),
    .latchIn(latchIn), .modeIn(modeIn), .openFlags(openFlags),
    .thermalFlag(thermalFlag), .sdataOut(sdataOut), .gsReg(gsReg), .dcReg(dcReg)
  );

  task automatic check(input string req, input logic [191:0] act, input logic [191:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [191:0] mkStatus(input logic [95:0] dc, input logic th, input logic [15:0] of);
    logic [191:0] s;
    s = '0;
    s[15:0] = of;
    s[16] = th;
    s[119:24] = dc;
    return s;
  endfunction

  task automatic pulseSclk(input logic d);
    sdataIn = d;
    @(negedge clk) sclkIn = 1'b1;
    @(negedge clk) sclkIn = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseLatch();
    @(negedge clk) latchIn = 1'b1;
    repeat (2) @(negedge clk);
    latchIn = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // Shift a 192-bit word, collecting what leaves sdataOut
  task automatic shiftGs(input logic [191:0] w, output logic [191:0] seen);
    for (int i = 191; i >= 0; i--) begin
      seen[i] = sdataOut;
      pulseSclk(w[i]);
    end
  endtask

  task automatic shiftDc(input logic [95:0] w, output logic [95:0] seen);
    for (int i = 95; i >= 0; i--) begin
      seen[i] = sdataOut;
      pulseSclk(w[i]);
    end
  endtask

  localparam logic [191:0] P1 = {64'h0123456789ABCDEF, 64'hFEDCBA9876543210, 64'h5A5AA5A5C3C33C3C};
  localparam logic [191:0] P2 = {64'h8000000000000001, 64'h00FF00FF00FF00FF, 64'h1357913579135791};
  localparam logic [191:0] P3 = {64'hFFF0000000000000, 64'hDEADBEEFCAFEF00D, 64'h0000000000000ABC};
  localparam logic [191:0] P4 = {64'h2468ACE02468ACE0, 64'h7777777777777777, 64'h9999999999999999};
  localparam logic [95:0]  D1 = 96'hFC0_3F0_0FC_FC0_123_456_789_ABC;
  localparam logic [95:0]  D2 = 96'h0A1_B2C_3D4_E5F_6A7_B8C_9D0_E1F;

  task automatic t_reset();
    check("R1 gsReg", gsReg, '0);
    check("R1 dcReg", {96'b0, dcReg}, '0);
    check("R1 sdataOut", {191'b0, sdataOut}, '0);
  endtask

  task automatic t_gs_load();
    logic [191:0] seen;
    modeIn = 1'b0;
    openFlags = 16'hA5C3;
    thermalFlag = 1'b1;
    shiftGs(P1, seen);
    check("R1 initial chain empty", seen, '0);
    pulseLatch();
    check("R2 gsReg full", gsReg, P1);
    check("R2 channel0 field", {180'b0, gsReg[11:0]}, {180'b0, P1[11:0]});
    check("R2 channel15 field", {180'b0, gsReg[191:180]}, {180'b0, P1[191:180]});
    check("R6 status MSB shown", {191'b0, sdataOut}, '0);
    shiftGs(P2, seen);
    check("R5 status readback", seen, mkStatus(96'b0, 1'b1, 16'hA5C3));
    check("R4 gsReg held while shifting", gsReg, P1);
    pulseLatch();
    check("R4 gsReg follows latch", gsReg, P2);
  endtask

  task automatic t_dc_load();
    logic [95:0] seen;
    modeIn = 1'b1;
    repeat (2) @(negedge clk);
    check("R8 gsReg kept on mode change", gsReg, P2);
    check("R8 dcReg kept on mode change", {96'b0, dcReg}, '0);
    shiftDc(D1, seen);
    pulseLatch();
    check("R3 dcReg full", {96'b0, dcReg}, {96'b0, D1});
    check("R3 channel0 field", {186'b0, dcReg[5:0]}, {186'b0, D1[5:0]});
    check("R6 DC chain top bit", {191'b0, sdataOut}, {191'b0, D1[95]});
    shiftDc(D2, seen);
    check("R3 daisy-chain 96-bit delay", {96'b0, seen}, {96'b0, D1});
    check("R4 dcReg held while shifting", {96'b0, dcReg}, {96'b0, D1});
    pulseLatch();
    check("R3 dcReg second load", {96'b0, dcReg}, {96'b0, D2});
    check("R4 gsReg untouched by DC latch", gsReg, P2);
  endtask

  task automatic t_gs_after_dc();
    logic [191:0] seen;
    modeIn = 1'b0;
    openFlags = 16'h1248;
    thermalFlag = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 dcReg kept on mode change back", {96'b0, dcReg}, {96'b0, D2});
    shiftGs(P3, seen);
    pulseLatch();
    check("R7 gsReg unchanged by first latch", gsReg, P2);
    check("R7 chain not yet replaced", {191'b0, sdataOut}, {191'b0, P3[191]});
    pulseSclk(1'b1);
    check("R7 gsReg updated on extra edge", gsReg, P3);
    check("R7 status MSB after extra edge", {191'b0, sdataOut}, '0);
    shiftGs(P4, seen);
    check("R7 R5 status intact after extra edge", seen, mkStatus(D2, 1'b0, 16'h1248));
    pulseLatch();
    check("R7 later latch acts at once", gsReg, P4);
  endtask

  task automatic t_hold();
    logic [191:0] seen;
    shiftGs(P1, seen);
    check("R5 status after normal latch", seen, mkStatus(D2, 1'b0, 16'h1248));
    check("R4 gsReg hold with latch low", gsReg, P4);
    check("R4 dcReg hold in GS mode", {96'b0, dcReg}, {96'b0, D2});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_gs_load();
    t_dc_load();
    t_gs_after_dc();
    t_hold();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule